// File: doc/BRIEF.md
# Stereo Offset Calibration Controller

The block sits in a stereo sample stream of 20-bit two's-complement samples. Each beat carries one channel: left beats carry a left flag, right beats do not, and a left beat followed by a right beat forms one frame (one sample period). While the inputs are held at zero, software or board logic starts a calibration cycle by pulsing an active-low control input. The block then waits a fixed number of clocks and opens a window of `WIN_FRAMES` frames. During that window it averages each channel and silences the output. From then on it subtracts the measured per-channel mean from every sample and saturates the result.

A cycle is only accepted while the active-low calibration enable is low. When the enable is high, samples pass through unchanged. Both the input and the output stream are valid/ready. A beat moves when valid and ready are both high at a rising clock edge. The input is ready whenever the output register is empty or is being drained in that same cycle (`in_ready = !out_valid || out_ready`). A stalled output beat holds its data and its flag, so back-pressure reaches the source without any beat being dropped, duplicated or reordered. Silencing replaces the sample value with zero but still emits the beat.

Top module: `offset_cal_ctrl`

## Requirements
- R1: When `cal_en_n` is high at the edge that accepts a beat, the output data equals the input data, with no offset removed. A control pulse released while `cal_en_n` is high starts no cycle.
- R2: A cycle starts only if `pd_n` was sampled low at 3 or more consecutive rising edges (`LOW_MIN`) and is then sampled high while `cal_en_n` is low and no cycle is running. A pulse of 2 low edges is ignored.
- R3: `cal_busy` rises at the 6th rising edge (`ARM_CLKS`) after the edge that first samples `pd_n` high.
- R4: Once busy, the window opens at the first accepted left beat. `cal_busy` falls at the edge that accepts the right beat completing frame number `WIN_FRAMES` (4096) of the window.
- R5: Every beat accepted while `cal_busy` is high, and every beat of the frame that follows the window, is emitted with data 0 and with its channel flag kept.
- R6: Each channel's offset is the sum of its window samples in a 32-bit accumulator, arithmetic-shifted right by log2(`WIN_FRAMES`) = 12. After the cycle, that offset is subtracted from every later sample of the same channel.
- R7: A corrected result outside the range -524288 to 524287 is clamped to the nearer bound.
- R8: Starting a new cycle clears both accumulators and both stored offsets before accumulation begins.
- R9: The output carries every accepted beat exactly once and in order. A beat stalled by `out_ready` low keeps its data and flag stable.
- R10: After reset, `cal_busy` and `out_valid` are low and both offsets are zero, so enabled samples pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low calibration request pulse |
| cal_en_n | input | 1 | Active-low calibration/correction enable |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_left | input | 1 | Input beat is the left channel |
| in_data | input | 20 | Input sample, two's complement |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_left | output | 1 | Output beat is the left channel |
| out_data | output | 20 | Corrected sample |
| cal_busy | output | 1 | High during the calibration window |

## Verification
The bench times `cal_busy` against the release edge to the exact clock, so a design that counts the arm delay off by one fails. It sends a low pulse that is one clock too short; a design that qualifies on two low clocks would start a cycle. The bench checks that the busy flag is still high before the last window frame and low right after it, and that the following frame is still silenced. A window that is one frame short or long, or a tail that is missing, shows up in those checks. It drives samples toward both rails so that a wrapping subtractor gives a sign-flipped value. It then runs a second cycle with different means, so stale accumulators or offsets give the wrong correction.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } cal_state_e;
endpackage

// File: rtl/ofc_release_detect.sv
module ofc_release_detect #(
  parameter int LOW_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic arm_ok,
  output logic start
);
  localparam int LCW = $clog2(LOW_MIN + 1);
  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!pd_n) begin
      if (low_cnt != LCW'(LOW_MIN)) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assign start = pd_n && (low_cnt == LCW'(LOW_MIN)) && arm_ok;
endmodule

// File: rtl/ofc_sequencer.sv
module ofc_sequencer
  import ofc_pkg::*;
#(
  parameter int WIN_FRAMES = 4096,
  parameter int ARM_CLKS   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic beat_fire,
  input  logic beat_left,
  output logic idle,
  output logic acc_en,
  output logic last_beat,
  output logic silence,
  output logic busy
);
  localparam int FCW  = $clog2(WIN_FRAMES);
  localparam int DLYW = (ARM_CLKS > 1) ? $clog2(ARM_CLKS) : 1;

  cal_state_e      state;
  logic [DLYW-1:0] dly;
  logic [FCW-1:0]  frames;
  logic            synced;

  assign idle      = (state == ST_IDLE);
  assign busy      = (state == ST_RUN);
  assign silence   = (state == ST_RUN) || (state == ST_TAIL);
  assign acc_en    = busy && beat_fire && (synced || beat_left);
  assign last_beat = acc_en && !beat_left && (frames == FCW'(WIN_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dly    <= '0;
      frames <= '0;
      synced <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_ARM;
          dly   <= '0;
        end
        ST_ARM: begin
          if (dly == DLYW'(ARM_CLKS - 1)) begin
            state  <= ST_RUN;
            frames <= '0;
            synced <= 1'b0;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        ST_RUN: begin
          if (acc_en && beat_left) synced <= 1'b1;
          if (acc_en && !beat_left) begin
            if (last_beat) state <= ST_TAIL;
            else frames <= frames + 1'b1;
          end
        end
        ST_TAIL: if (beat_fire && !beat_left) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ofc_offset_store.sv
module ofc_offset_store #(
  parameter int DW    = 20,
  parameter int ACC_W = 32,
  parameter int SHIFT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          acc_en,
  input  logic          last_beat,
  input  logic          beat_left,
  input  logic [DW-1:0] beat_data,
  output logic [DW-1:0] off_left,
  output logic [DW-1:0] off_right
);
  localparam int NCH = 2;
  logic [DW-1:0] off_q [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_next;
    logic [ACC_W-1:0] mean_src;
    logic [ACC_W-1:0] mean_full;
    logic             hit;

    assign hit       = acc_en && (beat_left == (ch == 0));
    assign sum_next  = acc + {{(ACC_W-DW){beat_data[DW-1]}}, beat_data};
    assign mean_src  = hit ? sum_next : acc;
    assign mean_full = ACC_W'($signed(mean_src) >>> SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc       <= '0;
        off_q[ch] <= '0;
      end else if (clear) begin
        acc       <= '0;
        off_q[ch] <= '0;
      end else begin
        if (hit) acc <= sum_next;
        if (last_beat) off_q[ch] <= mean_full[DW-1:0];
      end
    end
  end

  assign off_left  = off_q[0];
  assign off_right = off_q[1];
endmodule

// File: rtl/ofc_corrector.sv
module ofc_corrector #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_left,
  input  logic [DW-1:0] in_data,
  input  logic          bypass,
  input  logic          silence,
  input  logic [DW-1:0] off_left,
  input  logic [DW-1:0] off_right,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_left,
  output logic [DW-1:0] out_data
);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] off_sel;
  logic [DW:0]   diff;
  logic [DW-1:0] clamped;
  logic [DW-1:0] result;
  logic          fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign off_sel  = in_left ? off_left : off_right;
  assign diff     = {in_data[DW-1], in_data} - {off_sel[DW-1], off_sel};

  always_comb begin
    if (diff[DW] != diff[DW-1]) clamped = diff[DW] ? MAX_NEG : MAX_POS;
    else clamped = diff[DW-1:0];
  end

  always_comb begin
    if (silence)     result = '0;
    else if (bypass) result = in_data;
    else             result = clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_left  <= in_left;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/offset_cal_ctrl.sv
module offset_cal_ctrl #(
  parameter int DW         = 20,
  parameter int ACC_W      = 32,
  parameter int WIN_FRAMES = 4096,
  parameter int ARM_CLKS   = 6,
  parameter int LOW_MIN    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic          cal_en_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_left,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_left,
  output logic [DW-1:0] out_data,
  output logic          cal_busy
);
  localparam int SHIFT = $clog2(WIN_FRAMES);

  logic          start, idle, acc_en, last_beat, silence, fire;
  logic [DW-1:0] off_left, off_right;

  assign fire = in_valid && in_ready;

  ofc_release_detect #(.LOW_MIN(LOW_MIN)) u_rel (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .arm_ok(idle && !cal_en_n), .start(start)
  );

  ofc_sequencer #(.WIN_FRAMES(WIN_FRAMES), .ARM_CLKS(ARM_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_fire(fire),
    .beat_left(in_left), .idle(idle), .acc_en(acc_en),
    .last_beat(last_beat), .silence(silence), .busy(cal_busy)
  );

  ofc_offset_store #(.DW(DW), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(start), .acc_en(acc_en),
    .last_beat(last_beat), .beat_left(in_left), .beat_data(in_data),
    .off_left(off_left), .off_right(off_right)
  );

  ofc_corrector #(.DW(DW)) u_corr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_data(in_data), .bypass(cal_en_n),
    .silence(silence), .off_left(off_left), .off_right(off_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_data(out_data)
  );
endmodule

// File: rtl/offset_cal_ctrl_checker.sv
module offset_cal_ctrl_checker #(
  parameter int DW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_n,
  input logic          cal_en_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_left,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_left,
  input logic [DW-1:0] out_data,
  input logic          cal_busy,
  input logic          silence
);
  // R2 and R3: busy rises 6 edges after a release that followed 3 low samples
  a_r3_release_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> ($past(pd_n, 7) && !$past(pd_n, 8) && !$past(pd_n, 9)
                         && !$past(pd_n, 10) && !$past(cal_en_n, 7)));

  // R4: the window closes only on an accepted right beat
  a_r4_close_on_right: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> $past(in_valid && in_ready && !in_left));

  // R5: beats taken during the window come out as zero
  a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && in_valid && in_ready) |=> (out_valid && out_data == '0));

  // R1: with enable high and no silencing, data passes untouched
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cal_en_n && !silence) |=> (out_data == $past(in_data)));

  // R9: a stalled beat holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_left)));
endmodule

bind offset_cal_ctrl offset_cal_ctrl_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cal_en_n(cal_en_n),
  .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_left(out_left), .out_data(out_data), .cal_busy(cal_busy),
  .silence(silence)
);

// File: tb/offset_cal_ctrl_test.sv
module offset_cal_ctrl_test;
  localparam int DW  = 20;
  localparam int WIN = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pd_n = 1'b1;
  logic          cal_en_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_left = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b1;
  logic          in_ready, out_valid, out_left, cal_busy;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int outs_seen = 0;
  int beats_sent = 0;
  bit reported = 0;
  logic [DW:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  offset_cal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cal_en_n(cal_en_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_data(out_data), .cal_busy(cal_busy)
  );

  function automatic int sat20(input longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return int'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // Driver: records the expected beat, then offers it until accepted
  task automatic send(input bit left, input int val, input int expv, input string tag);
    exp_q.push_back({left, DW'(expv)});
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = left;
    in_data  = DW'(val);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    beats_sent++;
  endtask

  // Output back-pressure pattern, changed just after each edge
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
    end
  end

  // Monitor: compares each transferred beat against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        outs_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected beat", int'(out_data), 0);
        end else begin
          logic [DW:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_left == e[DW], {t, " flag"}, int'(out_left), int'(e[DW]));
          chk(out_data == e[DW-1:0], t,
              int'($signed(out_data)), int'($signed(e[DW-1:0])));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    summary();
    $finish;
  end

  task automatic pulse(input int lows);
    @(negedge clk);
    pd_n = 1'b0;
    repeat (lows - 1) @(negedge clk);
    @(negedge clk);
    pd_n = 1'b1;
  endtask

  task automatic busy_quiet(input string tag);
    repeat (12) begin
      @(negedge clk);
      chk(cal_busy == 1'b0, tag, int'(cal_busy), 0);
    end
  endtask

  // Full calibration with per-channel level plus a small ripple
  task automatic calibrate(input int lvl_l, input int lvl_r, output int mean_l, output int mean_r);
    longint sl = 0, sr = 0;
    pulse(4);
    repeat (6) @(negedge clk);
    chk(cal_busy == 1'b0, "R3 busy early", int'(cal_busy), 0);
    @(negedge clk);
    chk(cal_busy == 1'b1, "R3 busy on time", int'(cal_busy), 1);
    for (int i = 0; i < WIN; i++) begin
      int vl = lvl_l + (i % 5) - 2;
      int vr = lvl_r + (i % 7) - 1;
      sl += vl;
      sr += vr;
      if (i == WIN - 1) begin
        @(negedge clk);
        chk(cal_busy == 1'b1, "R4 busy before last frame", int'(cal_busy), 1);
      end
      send(1'b1, vl, 0, "R5 window left");
      send(1'b0, vr, 0, "R5 window right");
    end
    @(negedge clk);
    chk(cal_busy == 1'b0, "R4 busy after window", int'(cal_busy), 0);
    send(1'b1, 777, 0, "R5 tail left");
    send(1'b0, -777, 0, "R5 tail right");
    mean_l = int'(sl >>> 12);
    mean_r = int'(sr >>> 12);
  endtask

  initial begin
    int ml, mr;
    repeat (3) @(negedge clk);
    chk(cal_busy == 1'b0, "R10 busy in reset", int'(cal_busy), 0);
    chk(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cal_busy == 1'b0, "R10 busy after reset", int'(cal_busy), 0);
    send(1'b1, 12345, 12345, "R10 zero offset left");
    send(1'b0, -54321, -54321, "R10 zero offset right");

    cal_en_n = 1'b1;
    pulse(4);
    busy_quiet("R1 disabled pulse");
    cal_en_n = 1'b0;
    pulse(2);
    busy_quiet("R2 short pulse");

    calibrate(1000, -2000, ml, mr);
    send(1'b1, 5000, sat20(5000 - ml), "R6 corrected left");
    send(1'b0, 5000, sat20(5000 - mr), "R6 corrected right");
    send(1'b1, 0, sat20(-ml), "R6 zero left");
    send(1'b0, -300000, sat20(-300000 - mr), "R6 negative right");
    send(1'b1, -524288, sat20(-524288 - ml), "R7 clamp low");
    send(1'b0, 524287, sat20(524287 - mr), "R7 clamp high");
    send(1'b1, -523800, sat20(-523800 - ml), "R7 clamp near low");
    send(1'b0, 523000, sat20(523000 - mr), "R7 clamp near high");

    cal_en_n = 1'b1;
    send(1'b1, -524288, -524288, "R1 bypass left");
    send(1'b0, 4242, 4242, "R1 bypass right");
    cal_en_n = 1'b0;

    calibrate(50, -7, ml, mr);
    send(1'b1, 100000, sat20(100000 - ml), "R8 fresh offset left");
    send(1'b0, 100000, sat20(100000 - mr), "R8 fresh offset right");
    send(1'b1, -524288, sat20(-524288 - ml), "R8 R7 clamp after second cycle");
    send(1'b0, 1, sat20(1 - mr), "R8 small right");

    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all beats delivered", exp_q.size(), 0);
    chk(outs_seen == beats_sent, "R9 beat count", outs_seen, beats_sent);
    summary();
    $finish;
  end
endmodule